// File: doc/BRIEF.md
# Attribute memory read sequencer

This block sits on the host side of a removable memory card slot and performs single-word reads of the card's attribute memory space. A requester raises `req` with an address. The sequencer drives the address lines and pulls the register-select and primary chip-enable strobes low. After a setup interval it lowers output enable. It samples the 16-bit data bus only once every access limit has run out. At that same edge it releases all strobes and returns the word with a one-cycle `done` pulse.

Every interval is given in nanoseconds and turned into clock cycles by ceiling division against `CLK_PERIOD_NS`, so the same block fits any clock rate. After the strobes go high, the block stays busy for a recovery gap. During that gap the card may still be driving the data bus, and no new address may appear. Write enable and the secondary chip enable are never asserted, because only even-byte attribute reads are issued.

The request is a level. It is sampled only while the block is idle, so a requester that holds `req` high gets back-to-back cycles, each one spaced by the recovery gap.

Top module: `attr_read_seq`

## Requirements
- R1: After reset, `card_reg_n`, `card_ce1_n`, `card_ce2_n`, `card_oe_n` and `card_we_n` are high, `busy` and `done` are 0, and `rdata` and `card_a` are 0.
- R2: `card_ce2_n` and `card_we_n` stay high at all times.
- R3: When `req` is sampled high while idle, `card_reg_n` and `card_ce1_n` go low and `busy` goes high at that same edge.
- R4: `card_oe_n` goes low exactly S = ceil(30 ns / period) cycles after `card_ce1_n` goes low. It is low only while `card_ce1_n` and `card_reg_n` are low.
- R5: The data bus is sampled into `rdata` at cycle C = max(ceil(300/period), S + ceil(150/period)) after the start. At that edge `card_oe_n`, `card_ce1_n` and `card_reg_n` return high and `done` is high for exactly one cycle. `rdata` holds its value until the next capture. With the default 8 ns period, S = 4 and C = 38.
- R6: `card_a` carries the accepted address with bit 0 forced to 0. It stays unchanged from the start of a cycle until the start of the next one.
- R7: `busy` stays high for G = ceil(100/period) cycles after the strobes are released (13 at 8 ns). The next cycle starts no earlier than one cycle after `busy` falls, so more than 100 ns pass between strobe release and the next chip-enable fall.
- R8: `req` and `addr` are ignored while `busy` is high. A `req` that is still high once the block is idle starts a new cycle with the `addr` value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request level, sampled while idle |
| addr | input | ADDR_W | Attribute byte address of the request |
| busy | output | 1 | A cycle or its recovery gap is in progress |
| done | output | 1 | One-cycle pulse when rdata is updated |
| rdata | output | DATA_W | Last captured data word |
| card_a | output | ADDR_W | Card address lines |
| card_d | input | DATA_W | Card data bus |
| card_reg_n | output | 1 | Attribute space select, active low |
| card_ce1_n | output | 1 | Primary chip enable, active low |
| card_ce2_n | output | 1 | Secondary chip enable, held high |
| card_oe_n | output | 1 | Output enable, active low |
| card_we_n | output | 1 | Write enable, held high |

## Verification
A wrong phase counter or state register shows up at the strobe pins within one clock. The output-enable fall, the capture edge or the `busy` fall moves by whole cycles, and the per-clock model comparison flags that move on the very next falling clock edge. The bench's card model only presents valid data once the ns access limits, measured in real time, are met. A capture taken even one cycle early therefore returns a wrong word, and this is reported when `done` appears. A bad address latch shows either as a moved `card_a` during a busy cycle or as a wrong word for the held-request case.

// File: rtl/attr_rd_pkg.sv
`timescale 1ns/1ps
package attr_rd_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_SETUP   = 2'd1,
      PH_STROBE  = 2'd2,
      PH_RECOVER = 2'd3
   } phase_t;

   // ceiling conversion of a nanosecond limit into clock cycles
   function automatic int ns_to_cyc(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/attr_rd_timer.sv
`timescale 1ns/1ps
module attr_rd_timer #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W-1:0] count_inc;

   generate
      if (SATURATE) begin : g_sat
         assign count_inc = (&count) ? count : count + 1'b1;
      end else begin : g_wrap
         assign count_inc = count + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (restart) begin
         count <= '0;
      end else begin
         count <= count_inc;
      end
   end

endmodule

// File: rtl/attr_rd_ctrl.sv
`timescale 1ns/1ps
module attr_rd_ctrl
   import attr_rd_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SETUP_CYC   = 4,
   parameter int CAPTURE_CYC = 38,
   parameter int RECOVER_CYC = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [CNT_W-1:0] count,
   output logic             restart,
   output logic             load,
   output logic             capture,
   output logic             reg_n,
   output logic             ce_n,
   output logic             oe_n,
   output logic             busy,
   output logic             done
);

   localparam logic [CNT_W-1:0] SETUP_LAST   = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] CAPTURE_LAST = CNT_W'(CAPTURE_CYC - 1);
   localparam logic [CNT_W-1:0] RECOVER_LAST = CNT_W'(RECOVER_CYC - 1);

   phase_t phase, phase_nxt;

   always_comb begin
      phase_nxt = phase;
      restart   = 1'b0;
      load      = 1'b0;
      capture   = 1'b0;
      case (phase)
         PH_IDLE: begin
            if (req) begin
               load      = 1'b1;
               restart   = 1'b1;
               phase_nxt = PH_SETUP;
            end
         end
         PH_SETUP: begin
            if (count == SETUP_LAST) begin
               phase_nxt = PH_STROBE;
            end
         end
         PH_STROBE: begin
            if (count == CAPTURE_LAST) begin
               capture   = 1'b1;
               restart   = 1'b1;
               phase_nxt = PH_RECOVER;
            end
         end
         PH_RECOVER: begin
            if (count == RECOVER_LAST) begin
               phase_nxt = PH_IDLE;
            end
         end
         default: phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         reg_n <= 1'b1;
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         phase <= phase_nxt;
         reg_n <= !((phase_nxt == PH_SETUP) || (phase_nxt == PH_STROBE));
         ce_n  <= !((phase_nxt == PH_SETUP) || (phase_nxt == PH_STROBE));
         oe_n  <= !(phase_nxt == PH_STROBE);
         busy  <= (phase_nxt != PH_IDLE);
         done  <= capture;
      end
   end

endmodule

// File: rtl/attr_rd_datapath.sv
`timescale 1ns/1ps
module attr_rd_datapath #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 16,
   parameter bit EVEN_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              capture,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] card_d,
   output logic [ADDR_W-1:0] card_a,
   output logic [DATA_W-1:0] rdata
);

   logic [ADDR_W-1:0] addr_fmt;

   generate
      if (EVEN_ONLY) begin : g_even
         assign addr_fmt = {addr[ADDR_W-1:1], 1'b0};
      end else begin : g_any
         assign addr_fmt = addr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         card_a <= '0;
      end else if (load) begin
         card_a <= addr_fmt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (capture) begin
         rdata <= card_d;
      end
   end

endmodule

// File: rtl/attr_read_seq.sv
`timescale 1ns/1ps
module attr_read_seq
   import attr_rd_pkg::*;
#(
   parameter int CLK_PERIOD_NS   = 8,
   parameter int ADDR_W          = 11,
   parameter int DATA_W          = 16,
   parameter int T_SETUP_NS      = 30,
   parameter int T_CYCLE_NS      = 300,
   parameter int T_ADDR_ACC_NS   = 300,
   parameter int T_CE_ACC_NS     = 300,
   parameter int T_OE_ACC_NS     = 150,
   parameter int T_BUS_FREE_NS   = 100,
   parameter bit EVEN_ONLY       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] card_a,
   input  logic [DATA_W-1:0] card_d,
   output logic              card_reg_n,
   output logic              card_ce1_n,
   output logic              card_ce2_n,
   output logic              card_oe_n,
   output logic              card_we_n
);

   localparam int SETUP_CYC   = imax(1, ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS));
   localparam int OE_CYC      = imax(1, ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS));
   localparam int ACC_CYC     = imax(ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS),
                                 imax(ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                      ns_to_cyc(T_CE_ACC_NS, CLK_PERIOD_NS)));
   localparam int CAPTURE_CYC = imax(ACC_CYC, SETUP_CYC + OE_CYC);
   localparam int RECOVER_CYC = imax(1, ns_to_cyc(T_BUS_FREE_NS, CLK_PERIOD_NS));
   localparam int CNT_W       = $clog2(CAPTURE_CYC + RECOVER_CYC + 1) + 1;

   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("attr_read_seq: CLK_PERIOD_NS must be positive");
      end
      if (ADDR_W < 2 || DATA_W < 1) begin : g_bad_width
         $error("attr_read_seq: ADDR_W must be at least 2 and DATA_W at least 1");
      end
      if (T_SETUP_NS < 0 || T_OE_ACC_NS < 0 || T_BUS_FREE_NS < 0) begin : g_bad_time
         $error("attr_read_seq: timing limits must not be negative");
      end
   endgenerate

   logic             restart;
   logic             load;
   logic             capture;
   logic [CNT_W-1:0] count;

   attr_rd_timer #(
      .CNT_W    (CNT_W),
      .SATURATE (1'b1)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .count   (count)
   );

   attr_rd_ctrl #(
      .CNT_W       (CNT_W),
      .SETUP_CYC   (SETUP_CYC),
      .CAPTURE_CYC (CAPTURE_CYC),
      .RECOVER_CYC (RECOVER_CYC)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .count   (count),
      .restart (restart),
      .load    (load),
      .capture (capture),
      .reg_n   (card_reg_n),
      .ce_n    (card_ce1_n),
      .oe_n    (card_oe_n),
      .busy    (busy),
      .done    (done)
   );

   attr_rd_datapath #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .EVEN_ONLY (EVEN_ONLY)
   ) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .capture (capture),
      .addr    (addr),
      .card_d  (card_d),
      .card_a  (card_a),
      .rdata   (rdata)
   );

   assign card_ce2_n = 1'b1;
   assign card_we_n  = 1'b1;

endmodule

// File: rtl/attr_read_seq_chk.sv
`timescale 1ns/1ps
module attr_read_seq_chk #(
   parameter int ADDR_W      = 11,
   parameter int SETUP_CYC   = 4,
   parameter int RECOVER_CYC = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] card_a,
   input logic              card_reg_n,
   input logic              card_ce1_n,
   input logic              card_ce2_n,
   input logic              card_oe_n,
   input logic              card_we_n
);

   logic [15:0] ce_low_cnt;
   logic [15:0] ce_high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_low_cnt  <= '0;
         ce_high_cnt <= '1;
      end else begin
         ce_low_cnt  <= card_ce1_n ? 16'd0 : ((&ce_low_cnt) ? ce_low_cnt : ce_low_cnt + 16'd1);
         ce_high_cnt <= !card_ce1_n ? 16'd0 : ((&ce_high_cnt) ? ce_high_cnt : ce_high_cnt + 16'd1);
      end
   end

   // R2
   unused_strobes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_ce2_n && card_we_n);

   // R4
   oe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(card_oe_n) |-> (ce_low_cnt == 16'(SETUP_CYC)));

   // R4
   oe_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !card_oe_n |-> (!card_ce1_n && !card_reg_n));

   // R5
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (card_oe_n && card_ce1_n && card_reg_n && busy));

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(card_a));

   // R7
   bus_free_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(card_ce1_n) |-> (ce_high_cnt > 16'(RECOVER_CYC)));

   // R3
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !card_ce1_n |-> busy);

endmodule

bind attr_read_seq attr_read_seq_chk #(
   .ADDR_W      (ADDR_W),
   .SETUP_CYC   (SETUP_CYC),
   .RECOVER_CYC (RECOVER_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .card_a     (card_a),
   .card_reg_n (card_reg_n),
   .card_ce1_n (card_ce1_n),
   .card_ce2_n (card_ce2_n),
   .card_oe_n  (card_oe_n),
   .card_we_n  (card_we_n)
);

// File: tb/attr_read_seq_test.sv
`timescale 1ns/1ps
module attr_read_seq_test;

   localparam int PER   = 8;
   localparam int HALF  = PER / 2;
   localparam int AW    = 11;
   localparam int DW    = 16;
   localparam int NSU   = (30 + PER - 1) / PER;
   localparam int NOE   = (150 + PER - 1) / PER;
   localparam int NACC  = (300 + PER - 1) / PER;
   localparam int NC    = (NACC > NSU + NOE) ? NACC : NSU + NOE;
   localparam int NREL  = (100 + PER - 1) / PER;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] card_d = 16'h0BAD;
   logic          busy, done;
   logic [DW-1:0] rdata;
   logic [AW-1:0] card_a;
   logic          card_reg_n, card_ce1_n, card_ce2_n, card_oe_n, card_we_n;

   int n_chk = 0;
   int n_err = 0;
   bit cmp_on = 1'b0;

   always #(HALF) clk = ~clk;

   attr_read_seq #(.CLK_PERIOD_NS(PER)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .addr(addr),
      .busy(busy), .done(done), .rdata(rdata),
      .card_a(card_a), .card_d(card_d),
      .card_reg_n(card_reg_n), .card_ce1_n(card_ce1_n), .card_ce2_n(card_ce2_n),
      .card_oe_n(card_oe_n), .card_we_n(card_we_n)
   );

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return DW'(a * 16'h1357) ^ 16'hA5C3;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   int            m_n = 0;
   bit            m_busy = 1'b0;
   logic          m_ce = 1'b1, m_oe = 1'b1, m_done = 1'b0;
   logic [DW-1:0] m_rdata = '0;
   logic [AW-1:0] m_a = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_n = 0; m_busy = 1'b0; m_ce = 1'b1; m_oe = 1'b1; m_done = 1'b0;
         m_rdata = '0; m_a = '0;
      end else begin
         m_done = 1'b0;
         if (m_busy) begin
            m_n++;
            if (m_n == NSU) m_oe = 1'b0;
            if (m_n == NC) begin
               m_rdata = card_d; m_ce = 1'b1; m_oe = 1'b1; m_done = 1'b1;
            end
            if (m_n == NC + NREL) m_busy = 1'b0;
         end else if (req) begin
            m_busy = 1'b1; m_n = 0; m_a = {addr[AW-1:1], 1'b0}; m_ce = 1'b0;
         end
      end
      cmp_on = 1'b1;
   end

   // card model and ns timing monitor, evaluated mid-cycle
   longint        t_ce = 0, t_oe = 0, t_a = 0, t_rel = 0;
   bit            have_rel = 1'b0;
   logic          p_ce = 1'b1, p_oe = 1'b1;
   logic [AW-1:0] p_a = '0;

   always @(negedge clk) begin
      longint now;
      now = longint'($time) - HALF;
      if (cmp_on) begin
         chk(card_reg_n == m_ce, "R3 reg_n", 32'(card_reg_n), 32'(m_ce));
         chk(card_ce1_n == m_ce, "R3 ce1_n", 32'(card_ce1_n), 32'(m_ce));
         chk(card_oe_n == m_oe, "R4 oe_n", 32'(card_oe_n), 32'(m_oe));
         chk(card_ce2_n && card_we_n, "R2 ce2_n/we_n", {card_ce2_n, card_we_n}, 32'h3);
         chk(busy == m_busy, "R7 busy", 32'(busy), 32'(m_busy));
         chk(done == m_done, "R5 done", 32'(done), 32'(m_done));
         chk(rdata == m_rdata, "R5 rdata", 32'(rdata), 32'(m_rdata));
         chk(card_a == m_a, "R6 card_a", 32'(card_a), 32'(m_a));
      end
      if (p_ce && !card_ce1_n) begin
         t_ce = now;
         if (have_rel) chk((t_ce - t_rel) > 100, "R7 release gap ns", 32'(t_ce - t_rel), 32'd101);
      end
      if (p_oe && !card_oe_n) begin
         t_oe = now;
         chk((t_oe - t_ce) >= 30, "R4 setup ns", 32'(t_oe - t_ce), 32'd30);
      end
      if (!p_ce && card_ce1_n) begin
         t_rel = now; have_rel = 1'b1;
         chk((t_rel - t_ce) >= 300, "R5 ce access ns", 32'(t_rel - t_ce), 32'd300);
         chk((t_rel - t_oe) >= 150, "R5 oe access ns", 32'(t_rel - t_oe), 32'd150);
      end
      if (card_a != p_a) t_a = now;
      p_ce = card_ce1_n; p_oe = card_oe_n; p_a = card_a;
      now = longint'($time);
      if (!card_ce1_n && !card_oe_n && !card_reg_n &&
          (now - t_ce >= 300) && (now - t_oe >= 150) && (now - t_a >= 300))
         card_d = pat(card_a);
      else
         card_d = 16'h0BAD;
   end

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic read_one(input logic [AW-1:0] a);
      wait_idle();
      @(negedge clk);
      req = 1'b1; addr = a;
      @(negedge clk);
      req = 1'b0;
      chk(busy && !card_ce1_n, "R3 start", {busy, card_ce1_n}, 32'h2);
      wait_done();
      chk(rdata == pat({a[AW-1:1], 1'b0}), "R5 read word", 32'(rdata), 32'(pat({a[AW-1:1], 1'b0})));
      chk(card_a == {a[AW-1:1], 1'b0}, "R6 address even", 32'(card_a), 32'({a[AW-1:1], 1'b0}));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] held;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({card_reg_n, card_ce1_n, card_ce2_n, card_oe_n, card_we_n} == 5'h1F,
          "R1 strobes idle", 32'({card_reg_n, card_ce1_n, card_ce2_n, card_oe_n, card_we_n}), 32'h1F);
      chk(!busy && !done && rdata == '0 && card_a == '0, "R1 outputs idle",
          {busy, done, 14'(rdata), 11'(card_a)}, 32'h0);

      read_one(11'h000);
      read_one(11'h002);
      read_one(11'h7FE);
      read_one(11'h155);
      read_one(11'h2AA);
      held = rdata;
      repeat (30) @(negedge clk);
      chk(rdata == held, "R5 rdata holds", 32'(rdata), 32'(held));

      // R8 held request with an address change during busy
      wait_idle();
      @(negedge clk);
      req = 1'b1; addr = 11'h124;
      repeat (10) @(negedge clk);
      addr = 11'h3C8;
      repeat (5) @(negedge clk);
      chk(card_a == 11'h124, "R8 addr ignored while busy", 32'(card_a), 32'h124);
      wait_done();
      chk(rdata == pat(11'h124), "R8 first word", 32'(rdata), 32'(pat(11'h124)));
      while (busy) @(negedge clk);
      chk(card_ce1_n == 1'b1, "R7 idle cycle before restart", 32'(card_ce1_n), 32'h1);
      @(negedge clk);
      chk(!card_ce1_n && card_a == 11'h3C8, "R8 held req restarts", 32'(card_a), 32'h3C8);
      req = 1'b0;
      wait_done();
      chk(rdata == pat(11'h3C8), "R8 second word", 32'(rdata), 32'(pat(11'h3C8)));

      // R8 short request pulse while busy has no effect
      wait_idle();
      @(negedge clk);
      req = 1'b1; addr = 11'h040;
      @(negedge clk);
      req = 1'b0;
      repeat (8) @(negedge clk);
      req = 1'b1; addr = 11'h600;
      @(negedge clk);
      req = 1'b0;
      wait_done();
      chk(rdata == pat(11'h040), "R8 pulse word", 32'(rdata), 32'(pat(11'h040)));
      wait_idle();
      repeat (20) @(negedge clk);
      chk(!busy && card_ce1_n && card_a == 11'h040, "R8 pulse during busy dropped",
          {busy, card_ce1_n, 11'(card_a)}, {2'b01, 11'h040});

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule